// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a clocked host and an external asynchronous 64K x 8 static RAM. It accepts one single-beat read or write request at a time and plays out the matching strobe sequence on the memory pins. The memory side carries an address bus, a pair of select lines of opposite polarity, an active-low output enable, an active-low write enable and a shared, tri-stated 8-bit data bus. The controller raises both selects together and lowers them together.

Each phase of an access lasts a whole number of clock cycles. That number comes from nanosecond minimums given as parameters, divided by the clock period and rounded up. A write has three phases. A turnaround cycle comes first, with the output enable and write enable both high and the data drivers released. The write pulse follows, with the drivers on. A recovery phase then fills out the minimum write cycle. A read holds the output enable low for the access time. The controller captures the bus on the final clock of that access and hands the byte to the host with a one-cycle valid pulse.

States and transitions: `ST_IDLE` moves to `ST_WR_SETUP` on a write request or to `ST_RD_ACCESS` on a read request. `ST_WR_SETUP` moves to `ST_WR_PULSE` after one cycle. `ST_WR_PULSE` moves to `ST_WR_RECOVER` when its timer expires. `ST_WR_RECOVER` and `ST_RD_ACCESS` return to `ST_IDLE` when their timers expire.

Top module: `sram_ctl`

## Requirements
- R1: While reset is held and in the first cycle after it, busy and read-valid are 0. The memory is deselected (`mem_sel_n`=1, `mem_sel_p`=0), and `mem_oe_n`=1 and `mem_we_n`=1.
- R2: `mem_sel_n` is always the inverse of `mem_sel_p`. The memory is deselected in every cycle in which busy is 0.
- R3: A write runs as one turnaround cycle, then PULSE_CYC cycles with `mem_we_n`=0, then RECOVER_CYC cycles with `mem_we_n`=1 and the memory still selected. Busy is high for exactly 1+PULSE_CYC+RECOVER_CYC cycles.
- R4: During a write, `mem_oe_n` stays 1. The bus carries the accepted write byte in every cycle with `mem_we_n`=0.
- R5: The write pulse lasts exactly PULSE_CYC cycles. `mem_addr` and the write byte stay unchanged while the memory is selected. The time from selection to the end of the write is at least ceil(T_AW_NS/CLK_PERIOD_NS) cycles.
- R6: A read holds `mem_oe_n`=0 and `mem_we_n`=1 for exactly ACCESS_CYC cycles. The bus is sampled on the final clock of that window. `rvalid` is high for exactly one cycle, the first cycle in which busy is 0 again.
- R7: Busy rises in the cycle after a request is accepted in idle and stays high until the access ends. A request made while busy is ignored.
- R8: A read returns the byte last written to that address, including the lowest (0x0000) and highest (0xFFFF) addresses.
- R9: Each phase count is its minimum time divided by CLK_PERIOD_NS, rounded up. PULSE_CYC is the largest of the write-pulse count, the data-setup count and (address-to-end count minus 1). RECOVER_CYC is the write-cycle count minus 1 minus PULSE_CYC, and at least 1. ACCESS_CYC is the larger of the read-cycle count and the access-time count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request strobe, accepted when busy is 0 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address of the request |
| req_wdata | input | 8 | Byte to write |
| busy | output | 1 | High from the cycle after acceptance until the access ends |
| rdata | output | 8 | Byte returned by a read |
| rvalid | output | 1 | One-cycle pulse marking rdata valid |
| mem_addr | output | 16 | Memory address bus |
| mem_sel_n | output | 1 | Active-low memory select |
| mem_sel_p | output | 1 | Active-high memory select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq | inout | 8 | Bidirectional memory data bus |

## Verification
The bench builds the block with its default parameters: a 5 ns clock and timing minimums for a 25 ns part. These give a write pulse of 3 cycles, a recovery of 1 cycle and a read access of 5 cycles. With these values the address-to-end minimum lands exactly on the pulse length plus the turnaround cycle, and the recovery sits on its one-cycle floor, so an off-by-one in either rounding rule changes the observed busy length or the pulse count. The memory model returns the complement of the stored byte until the address has been read for the full access count, so a sample taken one clock early reads back wrong.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_WR_SETUP   = 3'd1,
        ST_WR_PULSE   = 3'd2,
        ST_WR_RECOVER = 3'd3,
        ST_RD_ACCESS  = 3'd4
    } ctl_state_e;

    // Nanosecond minimum to whole clock cycles, rounded up.
    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
`timescale 1ns/1ps
module sram_ctl_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    AST_TIMER_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R9

endmodule

// File: rtl/sram_ctl_fsm.sv
`timescale 1ns/1ps
module sram_ctl_fsm
    import sram_ctl_pkg::*;
#(
    parameter int PULSE_CYC   = 3,
    parameter int RECOVER_CYC = 1,
    parameter int ACCESS_CYC  = 5,
    parameter int CNT_W       = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             req_write,
    input  logic             tmr_expired,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_value,
    output logic             accept,
    output logic             sample,
    output logic             sel_q,
    output logic             oe_n_q,
    output logic             we_n_q,
    output logic             dq_oe_q,
    output logic             busy_q
);

    ctl_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    state_d = req_write ? ST_WR_SETUP : ST_RD_ACCESS;
                end
            end
            ST_WR_SETUP:   state_d = ST_WR_PULSE;
            ST_WR_PULSE:   if (tmr_expired) state_d = ST_WR_RECOVER;
            ST_WR_RECOVER: if (tmr_expired) state_d = ST_IDLE;
            ST_RD_ACCESS:  if (tmr_expired) state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // Phase timer reload on every state change
    always_comb begin
        tmr_load  = (state_d != state_q);
        tmr_value = '0;
        unique case (state_d)
            ST_WR_PULSE:   tmr_value = CNT_W'(PULSE_CYC - 1);
            ST_WR_RECOVER: tmr_value = CNT_W'(RECOVER_CYC - 1);
            ST_RD_ACCESS:  tmr_value = CNT_W'(ACCESS_CYC - 1);
            default:       tmr_value = '0;
        endcase
    end

    assign accept = (state_q == ST_IDLE) && req;
    assign sample = (state_q == ST_RD_ACCESS) && tmr_expired;

    // Output register: strobes decoded from the next state, so each pin
    // toggles glitch-free on the same edge as the state change.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q   <= 1'b0;
            oe_n_q  <= 1'b1;
            we_n_q  <= 1'b1;
            dq_oe_q <= 1'b0;
            busy_q  <= 1'b0;
        end else begin
            sel_q   <= (state_d != ST_IDLE);
            oe_n_q  <= (state_d != ST_RD_ACCESS);
            we_n_q  <= (state_d != ST_WR_PULSE);
            dq_oe_q <= (state_d == ST_WR_PULSE);
            busy_q  <= (state_d != ST_IDLE);
        end
    end

    // Checker counters for strobe widths
    logic [15:0] chk_we_low, chk_oe_low;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_we_low <= '0;
            chk_oe_low <= '0;
        end else begin
            chk_we_low <= we_n_q ? 16'd0 : chk_we_low + 16'd1;
            chk_oe_low <= oe_n_q ? 16'd0 : chk_oe_low + 16'd1;
        end
    end

    AST_WE_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n_q) |-> (chk_we_low == 16'(PULSE_CYC))); // R5
    AST_OE_WINDOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_n_q) |-> (chk_oe_low == 16'(ACCESS_CYC))); // R6
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy_q); // R7
    AST_NO_DRIVE_WITH_OE: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe_q |-> (oe_n_q && !we_n_q)); // R4

endmodule

// File: rtl/sram_ctl_datapath.sv
`timescale 1ns/1ps
module sram_ctl_datapath #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              sample,
    input  logic              dq_oe,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q,
    output logic              rvalid_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= sample;
            if (sample) begin
                rdata_q <= dq_in;
            end
        end
    end

    AST_RVALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_q |=> !rvalid_q); // R6
    AST_WDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe && $past(dq_oe)) |-> $stable(wdata_q)); // R5

endmodule

// File: rtl/sram_ctl.sv
`timescale 1ns/1ps
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W        = 16,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_NS = 5,
    parameter int T_RC_NS       = 25,
    parameter int T_AA_NS       = 25,
    parameter int T_WC_NS       = 25,
    parameter int T_PWE_NS      = 15,
    parameter int T_AW_NS       = 20,
    parameter int T_SD_NS       = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel_n,
    output logic              mem_sel_p,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    inout  wire  [DATA_W-1:0] mem_dq
);

    localparam int WC_CYC      = ceil_div(T_WC_NS,  CLK_PERIOD_NS);
    localparam int PWE_CYC     = ceil_div(T_PWE_NS, CLK_PERIOD_NS);
    localparam int SD_CYC      = ceil_div(T_SD_NS,  CLK_PERIOD_NS);
    localparam int AW_CYC      = ceil_div(T_AW_NS,  CLK_PERIOD_NS);
    localparam int RC_CYC      = ceil_div(T_RC_NS,  CLK_PERIOD_NS);
    localparam int AA_CYC      = ceil_div(T_AA_NS,  CLK_PERIOD_NS);
    // The turnaround cycle already has address and select valid.
    localparam int PULSE_CYC   = max2(max2(PWE_CYC, SD_CYC), max2(AW_CYC - 1, 1));
    localparam int RECOVER_CYC = max2(1, WC_CYC - 1 - PULSE_CYC);
    localparam int ACCESS_CYC  = max2(max2(RC_CYC, AA_CYC), 1);
    localparam int CNT_MAX     = max2(max2(PULSE_CYC, RECOVER_CYC), ACCESS_CYC);
    localparam int CNT_W       = max2($clog2(CNT_MAX + 1), 1);

    logic             tmr_load, tmr_expired, accept, sample;
    logic [CNT_W-1:0] tmr_value;
    logic             sel, dq_oe;
    logic [DATA_W-1:0] wdata_q;

    sram_ctl_fsm #(
        .PULSE_CYC   (PULSE_CYC),
        .RECOVER_CYC (RECOVER_CYC),
        .ACCESS_CYC  (ACCESS_CYC),
        .CNT_W       (CNT_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req),
        .req_write   (req_write),
        .tmr_expired (tmr_expired),
        .tmr_load    (tmr_load),
        .tmr_value   (tmr_value),
        .accept      (accept),
        .sample      (sample),
        .sel_q       (sel),
        .oe_n_q      (mem_oe_n),
        .we_n_q      (mem_we_n),
        .dq_oe_q     (dq_oe),
        .busy_q      (busy)
    );

    sram_ctl_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_value),
        .expired  (tmr_expired)
    );

    sram_ctl_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .sample    (sample),
        .dq_oe     (dq_oe),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .dq_in     (mem_dq),
        .addr_q    (mem_addr),
        .wdata_q   (wdata_q),
        .rdata_q   (rdata),
        .rvalid_q  (rvalid)
    );

    assign mem_sel_n = ~sel;
    assign mem_sel_p = sel;
    assign mem_dq    = dq_oe ? wdata_q : {DATA_W{1'bz}};

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && $past(sel)) |-> $stable(mem_addr)); // R5
    AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (mem_sel_n && !mem_sel_p)); // R2

endmodule

// File: tb/tb_sram_ctl.sv
`timescale 1ns/1ps
module tb_sram_ctl;

    // Expected phase lengths from R9 at a 5 ns clock and 25 ns part minimums
    localparam int EXP_PULSE   = 3;  // max(15/5, ceil(12/5), 20/5 - 1)
    localparam int EXP_RECOVER = 1;  // max(1, 5 - 1 - 3)
    localparam int EXP_ACCESS  = 5;  // max(25/5, 25/5)
    localparam int EXP_AW      = 4;
    localparam int EXP_WR_BUSY = 1 + EXP_PULSE + EXP_RECOVER;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        busy, rvalid, mem_sel_n, mem_sel_p, mem_oe_n, mem_we_n;
    logic [7:0]  rdata;
    logic [15:0] mem_addr;
    wire  [7:0]  mem_dq;
    logic        model_en = 1'b0;
    logic [7:0]  model_drv = '0;

    int n_checks = 0, n_fail = 0, cycles = 0;
    logic [7:0] exp_q[$];
    logic [7:0] shadow[int];
    logic [7:0] model_mem[int];
    logic [7:0] cur_wdata = '0;

    always #2.5 clk = ~clk;

    assign mem_dq = model_en ? model_drv : 8'bz;

    sram_ctl dut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy),
        .rdata(rdata), .rvalid(rvalid), .mem_addr(mem_addr),
        .mem_sel_n(mem_sel_n), .mem_sel_p(mem_sel_p), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_dq(mem_dq)
    );

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] mem_read(input int a);
        return model_mem.exists(a) ? model_mem[a] : 8'h00;
    endfunction

    // Behavioural memory model: truth table, phase lengths, storage
    int        sel_cnt = 0, wr_cnt = 0, wr_sel_at = 0, rd_age = 0;
    bit        wr_active = 0;
    logic [15:0] wr_addr = '0, rd_addr = '0;
    logic [7:0]  wr_data = '0;
    always @(negedge clk) begin
        if (!rst_n) begin
            sel_cnt = 0; wr_cnt = 0; wr_active = 0; rd_age = 0; model_en = 1'b0;
        end else begin
            bit sel;
            check(mem_sel_n == ~mem_sel_p, "R2 select polarity", mem_sel_n, ~mem_sel_p);
            if (!busy) check(mem_sel_n && !mem_sel_p, "R2 idle deselect", mem_sel_p, 0);
            sel = !mem_sel_n && mem_sel_p;
            sel_cnt = sel ? sel_cnt + 1 : 0;
            if (sel && !mem_we_n) begin
                check(mem_oe_n == 1'b1, "R4 oe high in write", mem_oe_n, 1);
                check(mem_dq == cur_wdata, "R4 write bus data", mem_dq, cur_wdata);
                if (wr_active) begin
                    check(mem_addr == wr_addr, "R5 addr held", mem_addr, wr_addr);
                    check(mem_dq == wr_data, "R5 data held", mem_dq, wr_data);
                end
                wr_active = 1; wr_cnt++; wr_addr = mem_addr;
                wr_data = mem_dq; wr_sel_at = sel_cnt;
            end else if (wr_active) begin
                check(sel, "R3 still selected in recovery", sel, 1);
                check(wr_cnt == EXP_PULSE, "R5 pulse length", wr_cnt, EXP_PULSE);
                check(wr_sel_at >= EXP_AW, "R5 select to write end", wr_sel_at, EXP_AW);
                model_mem[int'(wr_addr)] = wr_data;
                wr_active = 0; wr_cnt = 0;
            end
            if (sel && !mem_oe_n && mem_we_n) begin
                rd_age = (rd_age != 0 && mem_addr == rd_addr) ? rd_age + 1 : 1;
                rd_addr = mem_addr;
                model_drv = (rd_age >= EXP_ACCESS) ? mem_read(int'(mem_addr))
                                                   : ~mem_read(int'(mem_addr));
                model_en = 1'b1;
            end else begin
                rd_age = 0; model_en = 1'b0;
            end
        end
    end

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rvalid) begin
            if (exp_q.size() == 0) begin
                check(0, "R6 unexpected rvalid", 1, 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(rdata == e, "R8 read data", rdata, e);
            end
        end
    end

    // Driver: one request; extra_req re-asserts req during busy (R7)
    task automatic op(input bit wr, input logic [15:0] a, input logic [7:0] d,
                      input bit extra_req);
        int n;
        @(negedge clk);
        req = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        if (wr) begin
            cur_wdata = d;
            shadow[int'(a)] = d;
        end else begin
            exp_q.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00);
        end
        @(negedge clk);
        check(busy == 1'b1, "R7 busy after accept", busy, 1);
        check(mem_we_n == 1'b1 && mem_oe_n == (wr ? 1'b1 : 1'b0),
              wr ? "R3 turnaround strobes" : "R6 oe low in read",
              {mem_we_n, mem_oe_n}, {1'b1, wr});
        if (extra_req) begin
            req_write = 1'b1; req_addr = a ^ 16'h00FF; req_wdata = ~d;
        end else begin
            req = 1'b0;
        end
        n = 1;
        forever begin
            @(negedge clk);
            if (n >= 3) req = 1'b0;
            if (!busy) break;
            n++;
        end
        req = 1'b0;
        check(n == (wr ? EXP_WR_BUSY : EXP_ACCESS),
              wr ? "R3 write busy length" : "R9 read busy length",
              n, wr ? EXP_WR_BUSY : EXP_ACCESS);
        if (!wr) check(rvalid == 1'b1, "R6 rvalid at busy fall", rvalid, 1);
        else     check(rvalid == 1'b0, "R6 no rvalid on write", rvalid, 0);
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected<100000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        check(busy == 0 && rvalid == 0, "R1 reset busy/rvalid", {busy, rvalid}, 0);
        check(mem_sel_n == 1 && mem_sel_p == 0, "R1 reset deselect", {mem_sel_n, mem_sel_p}, 2);
        check(mem_oe_n == 1 && mem_we_n == 1, "R1 reset strobes", {mem_oe_n, mem_we_n}, 3);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 0 && mem_sel_n == 1, "R1 first cycle idle", {busy, mem_sel_n}, 1);

        // R8 boundary addresses
        op(1, 16'h0000, 8'hA5, 0);
        op(1, 16'hFFFF, 8'h3C, 0);
        op(0, 16'h0000, 8'h00, 0);
        op(0, 16'hFFFF, 8'h00, 0);
        // Overwrite then readback
        op(1, 16'h0000, 8'h5A, 0);
        op(0, 16'h0000, 8'h00, 0);

        // R7 request while busy is ignored
        op(1, 16'h12ED, 8'h11, 0);
        op(1, 16'h1212, 8'h77, 1);
        op(0, 16'h12ED, 8'h00, 0);
        op(0, 16'h1212, 8'h00, 0);

        // Random write / read-back pairs
        for (int i = 0; i < 32; i++) begin
            logic [15:0] a;
            a = 16'($urandom);
            op(1, a, 8'($urandom), 0);
        end
        foreach (shadow[k]) begin
            op(0, 16'(k), 8'h00, 0);
        end
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R6 all reads returned", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule